// File: doc/BRIEF.md
# Dead-Time Three-Phase PWM Compare Generator

This block keeps the compare values for a three-phase, centre-aligned motor PWM timer. A 16-bit counter runs in a triangle, up from zero to a top value and back down. Software loads a single duty value for each phase (U, V, W), a period value and a dead-time value Td. From each phase's duty value the block builds three compare registers. The down-count register holds the duty value itself. The middle register holds the duty value plus Td. The up-count register holds the duty value plus 2·Td. The top of the triangle is the period value plus 2·Td.

Every compare register is paired with the counter and gives a one-cycle hit pulse. A register can only hit in the count direction it belongs to. New compare data always arrives through a buffer register. A duty value written at its buffered address, and any period value, moves into the compare registers at the peak, the trough, both, or never, as the transfer-mode pins select. A duty value written at its free address takes effect on the clock that captures it.

The register write port is a plain strobe. A write is taken in the cycle `wr_en` is high, so the port has no ready signal and never back-pressures. Reads are combinational and have no side effects.

Top module: `dtpwm_cmpgen`

## Requirements
- R1: While `rst_n` is low and after its release, `cnt` is 0, `cnt_down` is 0 (counting up), and every buffer register reads 0.
- R2: While counting up below the top, `cnt` rises by 1 each clock. Once `cnt` has reached or passed the top (the period compare register), the next clock sets `cnt_down` and decrements `cnt`. While counting down, `cnt` falls by 1 each clock. When it reaches 0, the next clock clears `cnt_down` and sets `cnt` to 1.
- R3: Each phase's middle compare register equals its duty value plus Td. Its bit of `hit_mid` (bit 0 = U, 1 = V, 2 = W) pulses whenever `cnt` equals that register, in either direction.
- R4: Each phase's up-count compare register equals its duty value plus 2·Td. Its bit of `hit_up` pulses only while counting up, when `cnt` equals that register.
- R5: Each phase's down-count compare register equals its duty value. Its bit of `hit_dn` pulses only while counting down, when `cnt` equals that register.
- R6: The period compare register equals the period buffer plus 2·Td. It sets the peak of the triangle, and `hit_top` pulses only while counting up, when `cnt` equals it.
- R7: The period buffer and the buffered duty addresses move into the compare registers according to `xfer_mode`: 00 never, 01 on the clock leaving the peak, 10 on the clock leaving the trough, 11 on both. The transfer uses the current Td.
- R8: A write to a free duty address loads that phase's three compare registers on the same clock edge, using the current Td. It overrides a buffered transfer that happens at the same edge.
- R9: Address map for writes and reads: 0 = Td, 1 = period buffer, 2/3/4 = U/V/W duty buffered, 5/6/7 = U/V/W duty free. `rd_data` returns the addressed buffer. A free address and the buffered address of the same phase read the same buffer.
- R10: All offset sums wrap modulo 2^16 without saturation. For example, a duty value of 0xFFF0 with Td = 0x10 gives a middle register of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (map in R9) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address (map in R9) |
| rd_data | output | 16 | Addressed buffer contents |
| xfer_mode | input | 2 | Buffered transfer timing (R7) |
| cnt | output | 16 | Triangle counter value |
| cnt_down | output | 1 | 1 while counting down |
| hit_mid | output | 3 | Middle compare hits, per phase |
| hit_up | output | 3 | Up-count compare hits, per phase |
| hit_dn | output | 3 | Down-count compare hits, per phase |
| hit_top | output | 1 | Period compare hit |

## Verification
A cycle-by-cycle reference model predicts the counter and all ten hit lines. It runs while the transfer mode steps through 01, 00, 10 and 11. Each mode shows a different peak height once the period buffer changes, which separates peak, trough and disabled transfers. Buffered and free writes to the same phase separate deferred from immediate loading. Reading through both address aliases confirms a single buffer per phase. A large Td with a duty value near 0xFFFF separates wrapping arithmetic from saturating arithmetic.

// File: rtl/dtpwm_pkg.sv
package dtpwm_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned N_PH   = 3;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned A_DT    = 0;
  localparam int unsigned A_PER   = 1;
  localparam int unsigned A_BUF0  = 2;
  localparam int unsigned A_FREE0 = A_BUF0 + N_PH;
endpackage

// File: rtl/dtpwm_tri_counter.sv
module dtpwm_tri_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         down,
  output logic         at_peak,
  output logic         at_trough
);
  assign at_peak   = !down && (cnt >= top);
  assign at_trough = down && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (at_peak) begin
      down <= 1'b1;
      cnt  <= (cnt == '0) ? '0 : cnt - 1'b1;
    end else if (at_trough) begin
      down <= 1'b0;
      cnt  <= (top == '0) ? '0 : W'(1);
    end else if (down) begin
      cnt <= cnt - 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!down && cnt < top) |=> (!down && cnt == $past(cnt) + 1'b1));
  p_step_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (down && cnt != '0) |=> (down && cnt == $past(cnt) - 1'b1));
  p_turn_peak_r2: assert property (@(posedge clk) disable iff (!rst_n)
    at_peak |=> down);
  p_turn_trough_r2: assert property (@(posedge clk) disable iff (!rst_n)
    at_trough |=> !down);
endmodule

// File: rtl/dtpwm_phase.sv
module dtpwm_phase #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         buf_we,
  input  logic         free_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] dt,
  input  logic         xfer,
  input  logic [W-1:0] cnt,
  input  logic         down,
  output logic [W-1:0] buf_q,
  output logic         m_mid,
  output logic         m_up,
  output logic         m_dn
);
  logic [W-1:0] dn_r, mid_r, up_r;
  logic [W-1:0] src;
  logic         load;

  assign src  = free_we ? wdata : buf_q;
  assign load = free_we || xfer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      dn_r  <= '0;
      mid_r <= '0;
      up_r  <= '0;
    end else begin
      if (buf_we || free_we) buf_q <= wdata;
      if (load) begin
        dn_r  <= src;
        mid_r <= src + dt;
        up_r  <= src + {dt[W-2:0], 1'b0};
      end
    end
  end

  assign m_mid = (cnt == mid_r);
  assign m_up  = !down && (cnt == up_r);
  assign m_dn  = down && (cnt == dn_r);

  // R3/R4/R5: the three registers are always evenly spaced by one dead time
  p_even_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    W'(up_r - mid_r) == W'(mid_r - dn_r));
  p_free_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    free_we |=> (dn_r == $past(wdata) && buf_q == $past(wdata)));
endmodule

// File: rtl/dtpwm_cmpgen.sv
module dtpwm_cmpgen #(
  parameter int unsigned W  = dtpwm_pkg::CNT_W,
  parameter int unsigned AW = dtpwm_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic [1:0]    xfer_mode,
  output logic [W-1:0]  cnt,
  output logic          cnt_down,
  output logic [2:0]    hit_mid,
  output logic [2:0]    hit_up,
  output logic [2:0]    hit_dn,
  output logic          hit_top
);
  import dtpwm_pkg::*;
  localparam int unsigned NP = N_PH;

  logic [W-1:0] dt_r, pbuf_r, pcmp_r;
  logic         at_peak, at_trough, xfer;
  logic [W-1:0] phbuf [NP];

  dtpwm_tri_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .top(pcmp_r), .cnt(cnt), .down(cnt_down),
    .at_peak(at_peak), .at_trough(at_trough)
  );

  assign xfer = (at_peak && xfer_mode[0]) || (at_trough && xfer_mode[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dt_r   <= '0;
      pbuf_r <= '0;
      pcmp_r <= '0;
    end else begin
      if (wr_en && wr_addr == AW'(A_DT))  dt_r   <= wr_data;
      if (wr_en && wr_addr == AW'(A_PER)) pbuf_r <= wr_data;
      if (xfer) pcmp_r <= pbuf_r + {dt_r[W-2:0], 1'b0};
    end
  end

  assign hit_top = !cnt_down && (cnt == pcmp_r);

  for (genvar g = 0; g < NP; g++) begin : g_ph
    dtpwm_phase #(.W(W)) u_ph (
      .clk(clk), .rst_n(rst_n),
      .buf_we(wr_en && wr_addr == AW'(A_BUF0 + g)),
      .free_we(wr_en && wr_addr == AW'(A_FREE0 + g)),
      .wdata(wr_data), .dt(dt_r), .xfer(xfer),
      .cnt(cnt), .down(cnt_down), .buf_q(phbuf[g]),
      .m_mid(hit_mid[g]), .m_up(hit_up[g]), .m_dn(hit_dn[g])
    );
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(A_DT))  rd_data = dt_r;
    if (rd_addr == AW'(A_PER)) rd_data = pbuf_r;
    for (int i = 0; i < NP; i++)
      if (rd_addr == AW'(A_BUF0 + i) || rd_addr == AW'(A_FREE0 + i)) rd_data = phbuf[i];
  end

  p_top_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(at_peak || at_trough) |=> $stable(pcmp_r));
  p_mode_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_mode == 2'b00) |=> $stable(pcmp_r));
  p_top_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_top |=> cnt_down);
endmodule

// File: tb/dtpwm_cmpgen_test.sv
module dtpwm_cmpgen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  xfer_mode = 2'b00;
  logic [15:0] cnt;
  logic        cnt_down;
  logic [2:0]  hit_mid, hit_up, hit_dn;
  logic        hit_top;

  always #2 clk = ~clk;

  dtpwm_cmpgen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .xfer_mode(xfer_mode), .cnt(cnt),
    .cnt_down(cnt_down), .hit_mid(hit_mid), .hit_up(hit_up), .hit_dn(hit_dn),
    .hit_top(hit_top)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct {
    logic [15:0] c;
    logic        d;
    logic [2:0]  mm, mu, md;
    logic        mp;
  } exp_t;
  exp_t q[$];

  // reference model built from the requirements
  logic [15:0] m_cnt, m_dt, m_pbuf, m_pc;
  logic        m_down;
  logic [15:0] m_buf [3];
  logic [15:0] m_dn [3];
  logic [15:0] m_mid [3];
  logic [15:0] m_up [3];

  always @(posedge clk) begin
    logic pk, tr, xf;
    logic [15:0] dt_o, pb_o;
    logic [15:0] bf_o [3];
    exp_t e;
    if (!rst_n) begin
      m_cnt = 0; m_down = 0; m_dt = 0; m_pbuf = 0; m_pc = 0;
      for (int i = 0; i < 3; i++) begin
        m_buf[i] = 0; m_dn[i] = 0; m_mid[i] = 0; m_up[i] = 0;
      end
    end else begin
      pk = !m_down && (m_cnt >= m_pc);
      tr = m_down && (m_cnt == 0);
      xf = (pk && xfer_mode[0]) || (tr && xfer_mode[1]);
      dt_o = m_dt; pb_o = m_pbuf;
      for (int i = 0; i < 3; i++) bf_o[i] = m_buf[i];
      if (pk) begin m_down = 1; m_cnt = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1; end
      else if (tr) begin m_down = 0; m_cnt = (m_pc == 0) ? 16'd0 : 16'd1; end
      else if (m_down) m_cnt = m_cnt - 16'd1;
      else m_cnt = m_cnt + 16'd1;
      if (xf) begin
        m_pc = 16'(pb_o + 2 * dt_o);
        for (int i = 0; i < 3; i++) begin
          m_dn[i] = bf_o[i]; m_mid[i] = 16'(bf_o[i] + dt_o); m_up[i] = 16'(bf_o[i] + 2 * dt_o);
        end
      end
      if (wr_en) begin
        if (wr_addr == 0) m_dt = wr_data;
        else if (wr_addr == 1) m_pbuf = wr_data;
        else if (wr_addr < 5) m_buf[wr_addr - 2] = wr_data;
        else begin
          m_buf[wr_addr - 5] = wr_data;
          m_dn[wr_addr - 5]  = wr_data;
          m_mid[wr_addr - 5] = 16'(wr_data + dt_o);
          m_up[wr_addr - 5]  = 16'(wr_data + 2 * dt_o);
        end
      end
    end
    e.c = m_cnt; e.d = m_down;
    for (int i = 0; i < 3; i++) begin
      e.mm[i] = (m_cnt == m_mid[i]);
      e.mu[i] = !m_down && (m_cnt == m_up[i]);
      e.md[i] = m_down && (m_cnt == m_dn[i]);
    end
    e.mp = !m_down && (m_cnt == m_pc);
    q.push_back(e);
  end

  // monitor: compares outputs to predictions away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk("R2 count/direction", {cnt_down, cnt}, {e.d, e.c});
      chk("R3 hit_mid", hit_mid, e.mm);
      chk("R4 hit_up", hit_up, e.mu);
      chk("R5 hit_dn", hit_dn, e.md);
      chk("R6 hit_top", hit_top, e.mp);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk); rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  int w_max, w_mid_last, w_mid_n;
  task automatic watch(input int n);
    w_max = 0; w_mid_last = -1; w_mid_n = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (int'(cnt) > w_max) w_max = int'(cnt);
      if (hit_mid[0]) begin w_mid_last = int'(cnt); w_mid_n++; end
    end
  endtask

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset count", cnt, 0);
    chk("R1 reset direction", cnt_down, 0);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #1;
      chk("R1 reset buffer", rd_data, 0);
    end
    rst_n = 1;
    xfer_mode = 2'b01;
    wr(0, 3); wr(1, 20); wr(2, 5); wr(3, 10); wr(7, 7);
    watch(200);
    chk("R6 peak equals period+2Td", w_max, 26);
    rd(0, 3, "R9 dead time");
    rd(1, 20, "R9 period buffer");
    rd(2, 5, "R9 U buffered addr");
    rd(5, 5, "R9 U free alias");
    rd(3, 10, "R9 V buffered addr");
    rd(4, 7, "R9 W buffered alias");
    rd(7, 7, "R9 W free addr");
    // mode 00: buffered writes must not reach compare registers
    @(negedge clk); xfer_mode = 2'b00;
    wr(1, 40); wr(2, 12);
    watch(200);
    chk("R7 mode 00 keeps peak", w_max, 26);
    chk("R7 mode 00 keeps U middle", w_mid_last, 8);
    rd(5, 12, "R9 buffer updated in mode 00");
    // free write takes effect at once even in mode 00
    wr(5, 12);
    watch(200);
    chk("R8 free write moves U middle", w_mid_last, 15);
    chk("R8 free write leaves peak", w_max, 26);
    // trough transfer
    @(negedge clk); xfer_mode = 2'b10;
    watch(300);
    chk("R7 mode 10 trough transfer peak", w_max, 46);
    // both
    @(negedge clk); xfer_mode = 2'b11;
    wr(1, 30);
    repeat (120) @(negedge clk);
    watch(200);
    chk("R7 mode 11 peak", w_max, 36);
    // wrap-around arithmetic
    wr(0, 16'h0010);
    wr(5, 16'hFFF0);
    repeat (150) @(negedge clk);
    watch(300);
    chk("R10 middle wraps to 0", w_mid_last, 0);
    chk("R10 middle hit count nonzero", (w_mid_n > 0), 1);
    chk("R10 peak with new Td", w_max, 62);
    rd(0, 16'h0010, "R9 new dead time");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule